// File: doc/BRIEF.md
# Clock-Loss Reset and Init Sequencer

This block supervises the three clocks of an audio converter's serial interface: the master clock, the bit clock and the frame clock. It samples them from a free-running reference clock. While the external active-low reset is released, the loss of any one of these clocks puts the converter datapath into a reset state. In that state the serial data outputs and the zero-detect flags are held low, the DAC hold request is raised and a mute request is issued. The control register keeps its contents through this reset. Only the external reset returns it to its default value.

A clock counts as stopped when it shows no edge for `STOP_CYC` reference cycles. The reset state ends only after every clock has toggled within each of `RESTORE_WIN` back-to-back detection windows of `STOP_CYC` cycles. The ADC path then counts `ADC_INIT` rising frame-clock edges before its data is marked valid. Separately, the DAC path holds its output at midscale for `DAC_INIT` rising frame-clock edges. A clock loss during either count aborts both counts, and both start again from zero on the next exit. The mute request covers the whole reset state and a further `MUTE_CYC` reference cycles after the exit. Set `MUTE_CYC` to 20 µs worth of reference cycles.

Top module: `clk_loss_seq`

## Requirements
- R1: With `rst_ni` high, `in_reset_o` rises once any of `mclk_i`, `bclk_i` or `lrck_i` has had no edge for `STOP_CYC` reference cycles, within at most 5 further cycles. It stays low while all three clocks toggle with half periods well under `STOP_CYC`.
- R2: While `in_reset_o` is 1, `sdto_o` is 0 whatever `adc_sd_i` is (the ADC path delivers zero data). Otherwise `sdto_o` equals `adc_sd_i`.
- R3: While `in_reset_o` is 1, `dzf_o` is 0. Otherwise `dzf_o` equals `zdet_i`.
- R4: `cfg_o` takes `cfg_wdata_i` in the cycle after a cycle with `cfg_we_i` high. It is set to `CFG_RST` only by `rst_ni` low, and it keeps its value through a clock-loss reset.
- R5: When `in_reset_o` falls, `adc_init_o` rises in the same cycle. It falls on the `ADC_INIT`-th synchronised rising edge of `lrck_i`, and `adc_ready_o` pulses for exactly one cycle as it falls. `adc_valid_o` equals 1 only when both `adc_init_o` and `in_reset_o` are 0.
- R6: `dac_init_o` behaves like `adc_init_o` but with `DAC_INIT` edges, and it pulses `dac_ready_o`. `dac_hold_o` is 1 whenever `in_reset_o` or `dac_init_o` is 1, and 0 otherwise.
- R7: `in_reset_o` falls only after `RESTORE_WIN` consecutive windows of `STOP_CYC` cycles, in each of which all three clocks showed an edge. While any one clock stays stopped, it remains 1.
- R8: `mute_o` is 1 throughout the reset state. After `in_reset_o` falls it stays 1 for exactly `MUTE_CYC` cycles, then drops to 0.
- R9: A clock loss during initialisation clears `adc_init_o` and `dac_init_o` in the same cycle that `in_reset_o` rises. After the next exit both counts run their full length from zero.
- R10: After `rst_ni` is released, the block starts in the reset state (`in_reset_o`=1, `adc_init_o`=`dac_init_o`=0) and waits for the clocks to be restored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | free-running reference clock |
| rst_ni | input | 1 | external asynchronous reset, active low |
| mclk_i | input | 1 | monitored master clock |
| bclk_i | input | 1 | monitored bit clock |
| lrck_i | input | 1 | monitored frame clock, also the init count tick |
| adc_sd_i | input | 2 | serial data from the ADC core, two lines |
| zdet_i | input | 2 | zero-detect flags from the DAC core |
| cfg_we_i | input | 1 | control register write enable |
| cfg_wdata_i | input | CFG_W | control register write data |
| cfg_o | output | CFG_W | control register contents |
| sdto_o | output | 2 | gated serial data outputs |
| dzf_o | output | 2 | gated zero-detect flags |
| adc_valid_o | output | 1 | ADC data valid (no reset, no init) |
| dac_hold_o | output | 1 | hold DAC output at midscale |
| mute_o | output | 1 | mute request covering clock stop and start disturbances |
| in_reset_o | output | 1 | clock-loss reset state |
| adc_init_o | output | 1 | ADC init cycle running |
| dac_init_o | output | 1 | DAC init cycle running |
| adc_ready_o | output | 1 | one-cycle pulse when the ADC path enters normal operation |
| dac_ready_o | output | 1 | one-cycle pulse when the DAC path enters normal operation |

## Verification
The bound checker watches, on every cycle, the relations that hold at any instant. Outputs are quiet and init flags are clear while in reset. Both inits and the mute start together on exit. The valid and hold outputs agree with the state. Ready pulses coincide with the end of an init. The control register never moves without a write. The lengths can only be shown by bench scenarios: detection latency, the restore delay of several windows, the refusal to restore with one clock still missing, the exact mute length and init lengths counted in frame periods, the abort-and-restart of init, and register retention across a clock loss. The bench sweeps a loss of each clock in turn and checks these against arithmetic bounds.

// File: rtl/clk_loss_pkg.sv
package clk_loss_pkg;
  typedef enum logic {ST_LOSS = 1'b0, ST_RUN = 1'b1} seq_state_e;
  localparam int NUM_CLK = 3;
  localparam int IDX_LRCK = 2;
endpackage

// File: rtl/clk_act_mon.sv
module clk_act_mon #(
  parameter int STOP_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mon_i,
  output logic edge_o,
  output logic rise_o,
  output logic stopped_o
);
  localparam int CW = $clog2(STOP_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(STOP_CYC);

  logic [2:0]    sh_q;
  logic [CW-1:0] idle_q;

  // two-flop synchroniser plus one history flop for edge detection
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[1:0], mon_i};
  end

  assign edge_o = sh_q[2] ^ sh_q[1];
  assign rise_o = sh_q[1] & ~sh_q[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             idle_q <= '0;
    else if (edge_o)         idle_q <= '0;
    else if (idle_q != LIMIT) idle_q <= idle_q + 1'b1;
  end

  assign stopped_o = (idle_q == LIMIT);
endmodule

// File: rtl/loss_fsm.sv
module loss_fsm
  import clk_loss_pkg::*;
#(
  parameter int STOP_CYC    = 64,
  parameter int RESTORE_WIN = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CLK-1:0] edge_i,
  input  logic [NUM_CLK-1:0] stopped_i,
  output logic               in_reset_o,
  output logic               enter_o,
  output logic               leave_o
);
  localparam int WW = $clog2(STOP_CYC + 1);
  localparam int GW = $clog2(RESTORE_WIN + 1);
  localparam logic [WW-1:0] WIN_LAST  = WW'(STOP_CYC - 1);
  localparam logic [GW-1:0] GOOD_LAST = GW'(RESTORE_WIN - 1);

  seq_state_e         state_q;
  logic [WW-1:0]      win_q;
  logic [GW-1:0]      good_q;
  logic [NUM_CLK-1:0] seen_q;
  logic [NUM_CLK-1:0] seen_nxt;
  logic               win_end, all_seen;

  assign seen_nxt = seen_q | edge_i;
  assign all_seen = &seen_nxt;
  assign win_end  = (win_q == WIN_LAST);

  assign enter_o    = (state_q == ST_RUN) && (|stopped_i);
  assign leave_o    = (state_q == ST_LOSS) && win_end && all_seen && (good_q == GOOD_LAST);
  assign in_reset_o = (state_q == ST_LOSS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOSS;
      win_q   <= '0;
      good_q  <= '0;
      seen_q  <= '0;
    end else if (state_q == ST_RUN) begin
      if (enter_o) begin
        state_q <= ST_LOSS;
        win_q   <= '0;
        good_q  <= '0;
        seen_q  <= '0;
      end
    end else if (win_end) begin
      win_q  <= '0;
      seen_q <= '0;
      if (leave_o)       state_q <= ST_RUN;
      else if (all_seen) good_q  <= good_q + 1'b1;
      else               good_q  <= '0;
    end else begin
      win_q  <= win_q + 1'b1;
      seen_q <= seen_nxt;
    end
  end
endmodule

// File: rtl/init_seq.sv
module init_seq #(
  parameter int LEN = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  input  logic tick_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_o <= 1'b0;
      if (abort_i) begin
        busy_o <= 1'b0;
        cnt_q  <= '0;
      end else if (start_i) begin
        busy_o <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_o && tick_i) begin
        if (cnt_q == LAST) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/clk_loss_seq.sv
module clk_loss_seq
  import clk_loss_pkg::*;
#(
  parameter int              STOP_CYC    = 64,
  parameter int              RESTORE_WIN = 8,
  parameter int              ADC_INIT    = 516,
  parameter int              DAC_INIT    = 512,
  parameter int              MUTE_CYC    = 2500,
  parameter int              CFG_W       = 8,
  parameter logic [CFG_W-1:0] CFG_RST    = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mclk_i,
  input  logic             bclk_i,
  input  logic             lrck_i,
  input  logic [1:0]       adc_sd_i,
  input  logic [1:0]       zdet_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic [1:0]       sdto_o,
  output logic [1:0]       dzf_o,
  output logic             adc_valid_o,
  output logic             dac_hold_o,
  output logic             mute_o,
  output logic             in_reset_o,
  output logic             adc_init_o,
  output logic             dac_init_o,
  output logic             adc_ready_o,
  output logic             dac_ready_o
);
  localparam int MW = $clog2(MUTE_CYC + 1);
  localparam logic [MW-1:0] MUTE_LD = MW'(MUTE_CYC);

  logic [NUM_CLK-1:0] mon_clk, edge_v, rise_v, stop_v;
  logic               enter, leave;
  logic [MW-1:0]      mute_q;
  logic               unused_rise;

  assign mon_clk     = {lrck_i, bclk_i, mclk_i};
  assign unused_rise = ^rise_v[NUM_CLK-2:0];

  for (genvar g = 0; g < NUM_CLK; g++) begin : g_mon
    clk_act_mon #(.STOP_CYC(STOP_CYC)) u_mon (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .mon_i    (mon_clk[g]),
      .edge_o   (edge_v[g]),
      .rise_o   (rise_v[g]),
      .stopped_o(stop_v[g])
    );
  end

  loss_fsm #(.STOP_CYC(STOP_CYC), .RESTORE_WIN(RESTORE_WIN)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .edge_i    (edge_v),
    .stopped_i (stop_v),
    .in_reset_o(in_reset_o),
    .enter_o   (enter),
    .leave_o   (leave)
  );

  init_seq #(.LEN(ADC_INIT)) u_adc_init (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(leave),
    .abort_i(enter),
    .tick_i (rise_v[IDX_LRCK]),
    .busy_o (adc_init_o),
    .done_o (adc_ready_o)
  );

  init_seq #(.LEN(DAC_INIT)) u_dac_init (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(leave),
    .abort_i(enter),
    .tick_i (rise_v[IDX_LRCK]),
    .busy_o (dac_init_o),
    .done_o (dac_ready_o)
  );

  // tail of mute after exit; the reset state itself mutes via in_reset_o
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           mute_q <= '0;
    else if (leave)        mute_q <= MUTE_LD;
    else if (mute_q != '0) mute_q <= mute_q - 1'b1;
  end

  // only the external reset initialises the register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_o <= CFG_RST;
    else if (cfg_we_i) cfg_o <= cfg_wdata_i;
  end

  assign mute_o      = in_reset_o | (mute_q != '0);
  assign sdto_o      = in_reset_o ? 2'b00 : adc_sd_i;
  assign dzf_o       = in_reset_o ? 2'b00 : zdet_i;
  assign adc_valid_o = ~in_reset_o & ~adc_init_o;
  assign dac_hold_o  = in_reset_o | dac_init_o;
endmodule

// File: rtl/clk_loss_seq_chk.sv
module clk_loss_seq_chk #(
  parameter int CFG_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic [CFG_W-1:0] cfg_o,
  input logic [1:0]       sdto_o,
  input logic [1:0]       dzf_o,
  input logic             adc_valid_o,
  input logic             dac_hold_o,
  input logic             mute_o,
  input logic             in_reset_o,
  input logic             adc_init_o,
  input logic             dac_init_o,
  input logic             adc_ready_o,
  input logic             dac_ready_o
);
  AST_SDTO_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_reset_o |-> (sdto_o == 2'b00)); // R2
  AST_DZF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_reset_o |-> (dzf_o == 2'b00)); // R3
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(cfg_o)); // R4
  AST_INIT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_reset_o) |-> (adc_init_o && dac_init_o)); // R5
  AST_VALID_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_valid_o |-> (!adc_init_o && !in_reset_o)); // R5
  AST_ADC_READY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_ready_o |-> $fell(adc_init_o)); // R5
  AST_DAC_READY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_ready_o |-> $fell(dac_init_o)); // R6
  AST_DAC_HOLD_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_init_o |-> dac_hold_o); // R6
  AST_MUTE_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_reset_o) |-> mute_o); // R8
  AST_INIT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_reset_o |-> (!adc_init_o && !dac_init_o)); // R9
endmodule

bind clk_loss_seq clk_loss_seq_chk #(.CFG_W(CFG_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .cfg_o      (cfg_o),
  .sdto_o     (sdto_o),
  .dzf_o      (dzf_o),
  .adc_valid_o(adc_valid_o),
  .dac_hold_o (dac_hold_o),
  .mute_o     (mute_o),
  .in_reset_o (in_reset_o),
  .adc_init_o (adc_init_o),
  .dac_init_o (dac_init_o),
  .adc_ready_o(adc_ready_o),
  .dac_ready_o(dac_ready_o)
);

// File: tb/sim_clk_loss_seq.sv
module sim_clk_loss_seq;
  localparam int STOP = 32, RW = 4, ADC = 12, DAC = 8, MUTE = 40, CW = 8;
  localparam logic [CW-1:0] CRST = 8'h3C;
  localparam int PM = 4, PB = 8, PL = 32;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic en_m = 1'b0, en_b = 1'b0, en_l = 1'b0;
  logic mclk = 1'b0, bclk = 1'b0, lrck = 1'b0;
  int cm = 0, cb = 0, cl = 0;

  always @(negedge clk) begin
    if (en_m) begin if (cm == PM/2-1) begin cm <= 0; mclk <= ~mclk; end else cm <= cm + 1; end
    if (en_b) begin if (cb == PB/2-1) begin cb <= 0; bclk <= ~bclk; end else cb <= cb + 1; end
    if (en_l) begin if (cl == PL/2-1) begin cl <= 0; lrck <= ~lrck; end else cl <= cl + 1; end
  end

  logic [1:0]    adc_sd = 2'b00, zdet = 2'b00;
  logic          cfg_we = 1'b0;
  logic [CW-1:0] cfg_wdata = '0;
  logic [CW-1:0] cfg_o;
  logic [1:0]    sdto_o, dzf_o;
  logic adc_valid_o, dac_hold_o, mute_o, in_reset_o, adc_init_o, dac_init_o, adc_ready_o, dac_ready_o;

  clk_loss_seq #(
    .STOP_CYC(STOP), .RESTORE_WIN(RW), .ADC_INIT(ADC), .DAC_INIT(DAC),
    .MUTE_CYC(MUTE), .CFG_W(CW), .CFG_RST(CRST)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mclk_i(mclk), .bclk_i(bclk), .lrck_i(lrck),
    .adc_sd_i(adc_sd), .zdet_i(zdet), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cfg_o(cfg_o), .sdto_o(sdto_o), .dzf_o(dzf_o), .adc_valid_o(adc_valid_o),
    .dac_hold_o(dac_hold_o), .mute_o(mute_o), .in_reset_o(in_reset_o),
    .adc_init_o(adc_init_o), .dac_init_o(dac_init_o),
    .adc_ready_o(adc_ready_o), .dac_ready_o(dac_ready_o)
  );

  int total = 0, bad = 0;
  bit ended = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_en(input int k, input logic v);
    case (k)
      0: en_m = v;
      1: en_b = v;
      default: en_l = v;
    endcase
  endtask

  task automatic write_cfg(input logic [CW-1:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // wait for exit, then measure mute tail and both init lengths
  task automatic recover(input string tag);
    int n = 0;
    int mute_n = 0, adc_n = 0, dac_n = 0, ar = 0, dr = 0, vbad = 0, hbad = 0;
    while (in_reset_o && n < (RW + 4) * STOP) begin @(negedge clk); n++; end
    chk(n >= (RW - 1) * STOP && n <= (RW + 2) * STOP, "R7", {tag, " restore delay"}, n, RW * STOP);
    chk(adc_init_o && dac_init_o, "R5", {tag, " inits start at exit"}, {adc_init_o, dac_init_o}, 3);
    for (int i = 0; i < ADC * PL + MUTE + 100; i++) begin
      if (mute_o) mute_n++;
      if (adc_init_o) adc_n++;
      if (dac_init_o) dac_n++;
      if (adc_ready_o) ar++;
      if (dac_ready_o) dr++;
      if (adc_valid_o != (!adc_init_o && !in_reset_o)) vbad++;
      if (dac_hold_o != (dac_init_o || in_reset_o)) hbad++;
      @(negedge clk);
    end
    chk(mute_n == MUTE, "R8", {tag, " mute tail"}, mute_n, MUTE);
    chk(adc_n >= (ADC - 1) * PL && adc_n <= ADC * PL + 6, "R5", {tag, " adc init length"}, adc_n, ADC * PL);
    chk(dac_n >= (DAC - 1) * PL && dac_n <= DAC * PL + 6, "R6", {tag, " dac init length"}, dac_n, DAC * PL);
    chk(ar == 1, "R5", {tag, " adc ready pulses"}, ar, 1);
    chk(dr == 1, "R6", {tag, " dac ready pulses"}, dr, 1);
    chk(vbad == 0, "R5", {tag, " valid mismatches"}, vbad, 0);
    chk(hbad == 0, "R6", {tag, " hold mismatches"}, hbad, 0);
  endtask

  task automatic check_quiet(input string tag);
    adc_sd = 2'b11; zdet = 2'b11;
    @(negedge clk);
    chk(sdto_o == 2'b00, "R2", {tag, " sdto in reset"}, sdto_o, 0);
    chk(dzf_o == 2'b00, "R3", {tag, " dzf in reset"}, dzf_o, 0);
    chk(cfg_o == 8'hA5, "R4", {tag, " cfg kept"}, cfg_o, 8'hA5);
    chk(mute_o && dac_hold_o && !adc_valid_o, "R8", {tag, " mute/hold in reset"},
        {mute_o, dac_hold_o, adc_valid_o}, 6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired act=%0d exp=%0d", total, 0);
    finish_run();
  end

  initial begin
    cyc(3);
    chk(cfg_o == CRST, "R4", "cfg reset value", cfg_o, CRST);
    chk(in_reset_o == 1'b1, "R10", "in reset during rst_ni", in_reset_o, 1);
    rst_ni = 1'b1;
    cyc(2);
    chk(in_reset_o && !adc_init_o && !dac_init_o, "R10", "post-reset state",
        {in_reset_o, adc_init_o, dac_init_o}, 4);
    chk(mute_o == 1'b1, "R8", "mute at start", mute_o, 1);
    write_cfg(8'hA5);
    chk(cfg_o == 8'hA5, "R4", "cfg write", cfg_o, 8'hA5);
    cyc(3 * STOP);
    chk(in_reset_o == 1'b1, "R10", "no clocks stays in reset", in_reset_o, 1);

    en_m = 1; en_b = 1; en_l = 1;
    recover("power-up");
    adc_sd = 2'b10; zdet = 2'b01;
    @(negedge clk);
    chk(sdto_o == 2'b10, "R2", "sdto pass-through", sdto_o, 2);
    chk(dzf_o == 2'b01, "R3", "dzf pass-through", dzf_o, 1);
    chk(adc_valid_o == 1'b1, "R5", "adc valid after init", adc_valid_o, 1);

    // sweep: loss of each clock in turn
    for (int k = 0; k < 3; k++) begin
      adc_sd = 2'b11; zdet = 2'b11;
      set_en(k, 1'b0);
      cyc(8);
      chk(in_reset_o == 1'b0, "R1", $sformatf("clk%0d not early", k), in_reset_o, 0);
      cyc(STOP);
      chk(in_reset_o == 1'b1, "R1", $sformatf("clk%0d loss detected", k), in_reset_o, 1);
      check_quiet($sformatf("clk%0d", k));
      set_en(k, 1'b1);
      recover($sformatf("clk%0d restart", k));
    end

    // one clock still missing keeps the reset state
    en_m = 0; en_l = 0;
    cyc(STOP + 8);
    chk(in_reset_o == 1'b1, "R1", "two clocks lost", in_reset_o, 1);
    en_m = 1;
    cyc((RW + 3) * STOP);
    chk(in_reset_o == 1'b1, "R7", "lrck still missing", in_reset_o, 1);
    en_l = 1;
    recover("partial restore");

    // loss during init aborts and restarts
    en_b = 0;
    cyc(STOP + 8);
    en_b = 1;
    while (in_reset_o) @(negedge clk);
    cyc(5 * PL);
    chk(adc_init_o && dac_init_o, "R9", "mid-init", {adc_init_o, dac_init_o}, 3);
    en_b = 0;
    cyc(STOP + 8);
    chk(in_reset_o && !adc_init_o && !dac_init_o, "R9", "init aborted",
        {in_reset_o, adc_init_o, dac_init_o}, 4);
    en_b = 1;
    recover("R9 restart");

    // only the external reset restores the default
    write_cfg(8'h5A);
    rst_ni = 1'b0;
    cyc(2);
    chk(cfg_o == CRST, "R4", "external reset clears cfg", cfg_o, CRST);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(in_reset_o == 1'b1, "R10", "reset state after rst_ni", in_reset_o, 1);
    recover("after rst_ni");

    finish_run();
  end
endmodule